// File: doc/BRIEF.md
# Vertical Field Countdown Synchronizer

This block produces the vertical field timing of a raster display from a clock that runs at 32 times the horizontal line rate, so one line spans 32 clocks and one half-line spans 16. A field counter restarts either on a qualified vertical sync pulse or on its own terminal count. The block emits a one-clock ramp reset at every restart and a blanking gate that opens with it.

The block has two field lengths. An interlaced signal that carries nine equalizing serrations on the composite sync input gives a locked field of 8400 clocks (525 half-lines). When sync is absent or not qualified, the counter free-runs with a field of 10944 clocks. Once locked, a confidence filter lets short sync dropouts pass without leaving lock. An out-of-phase detector re-phases the counter after eight consecutive displaced sync pulses. A fast-resync path locks on the next field when, in free-run, a short noise pulse appears on the vertical sync line in the middle of a field.

Top module: `vfield_sync`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it, `ramp_o` is 0, `blank_o` is 1 and `locked_o` is 0. The field counter starts at 0 and the block is unlocked.
- R2: When unlocked and with no sync restart, `ramp_o` pulses every 10944 clocks.
- R3: A rising edge on `vsync_i` restarts an unlocked field only if the field count is at least 7872 at that edge. `ramp_o` is then high in the following cycle. Earlier edges are ignored.
- R4: A field is qualified when at least 9 rising edges of `csync_i` are counted during it. A restart that ends a qualified field sets `locked_o` to 1. A field with 8 counted edges does not qualify. While locked, the field lasts 8400 clocks.
- R5: While locked, each unqualified field end increments a miss count, and a qualified one clears it. On the 7th consecutive unqualified field end, `locked_o` falls and the field returns to 10944 clocks.
- R6: While locked, a `vsync_i` rising edge at a count of at least 7872 that does not coincide with the field's last count is out of phase. The first seven consecutive such edges leave the field running. The eighth restarts the field on that edge, and `ramp_o` is high in the next cycle. An in-phase edge clears the tally.
- R7: While unlocked and automatic, a `vsync_i` pulse that rises at a field count from 4000 to 6000 and stays high for 5 to 50 clocks makes the next field restart set `locked_o` to 1, with no serrations needed.
- R8: `ramp_o` is a single-clock pulse. `blank_o` is high for the first 672 clocks of each field, counted from the cycle in which `ramp_o` is high.
- R9: With `auto_i` at 0 (forced free-run), `locked_o` is 0 from the next cycle on. `vsync_i` and `csync_i` have no effect, and fields last 10944 clocks. `auto_i` at 1 selects automatic operation.
- R10: Serrations are counted only while the field count is at least 7872. Edges earlier in the field do not count toward qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock, 32 times the line rate |
| rst_i | input | 1 | Synchronous reset, active high |
| csync_i | input | 1 | Composite sync, source of the serration edges |
| vsync_i | input | 1 | Separated vertical sync |
| auto_i | input | 1 | 1 = automatic sync, 0 = forced free-run |
| ramp_o | output | 1 | One-clock ramp reset at each field restart |
| blank_o | output | 1 | Vertical blanking gate |
| locked_o | output | 1 | 1 while in the locked 8400-clock mode |

## Verification
A wrong lock flag or miss count shows up first as a field length change: the next `ramp_o` arrives 2544 clocks early or late, within one field of the fault. A corrupted phase tally moves the restart to the edge of a displaced sync pulse, which is seen one cycle after that edge. A serration counter that counts outside its window locks the block one field too soon, and `locked_o` reveals this in the cycle after the restart. The bench's cycle model compares all three outputs on every clock, so any such divergence is caught at the first cycle in which it is visible at the ports.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
   typedef enum logic {
      LOCK_FREE = 1'b0,
      LOCK_SYNC = 1'b1
   } lock_e;

   function automatic int unsigned bits_for(input int unsigned value);
      return (value < 2) ? 1 : $clog2(value + 1);
   endfunction
endpackage

// File: rtl/vfs_field_ctr.sv
module vfs_field_ctr #(
   parameter int unsigned SYNC_LEN  = 8400,
   parameter int unsigned FREE_LEN  = 10944,
   parameter int unsigned HOLDOFF   = 7872,
   parameter int unsigned BLANK_LEN = 672,
   parameter int unsigned CNT_W     = 14
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             locked_i,
   input  logic             cut_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o,
   output logic             in_win_o,
   output logic             restart_o,
   output logic             ramp_o,
   output logic             blank_o
);
   localparam logic [CNT_W-1:0] SYNC_END  = CNT_W'(SYNC_LEN - 1);
   localparam logic [CNT_W-1:0] FREE_END  = CNT_W'(FREE_LEN - 1);
   localparam logic [CNT_W-1:0] HOLD_C    = CNT_W'(HOLDOFF);
   localparam logic [CNT_W-1:0] BLANK_C   = CNT_W'(BLANK_LEN);

   logic [CNT_W-1:0] cnt_q;
   logic             ramp_q;

   always_comb begin
      wrap_o    = (cnt_q == (locked_i ? SYNC_END : FREE_END));
      in_win_o  = (cnt_q >= HOLD_C);
      restart_o = wrap_o | cut_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         ramp_q <= 1'b0;
      end else begin
         cnt_q  <= restart_o ? '0 : cnt_q + 1'b1;
         ramp_q <= restart_o;
      end
   end

   assign cnt_o   = cnt_q;
   assign ramp_o  = ramp_q;
   assign blank_o = (cnt_q < BLANK_C);

   a_r3_restart_after_holdoff: assert property (@(posedge clk_i) disable iff (rst_i)
      restart_o |-> (cnt_q >= HOLD_C));
   a_r2_count_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= FREE_END);
   a_r4_locked_field_short: assert property (@(posedge clk_i) disable iff (rst_i)
      locked_i |-> (cnt_q <= SYNC_END));
   a_r8_ramp_single: assert property (@(posedge clk_i) disable iff (rst_i)
      ramp_o |=> !ramp_o);
   a_r8_ramp_in_blank: assert property (@(posedge clk_i) disable iff (rst_i)
      ramp_o |-> blank_o);
endmodule

// File: rtl/vfs_serr_ctr.sv
module vfs_serr_ctr #(
   parameter int unsigned SERR_NEED = 9,
   parameter int unsigned SERR_W    = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic cs_i,
   input  logic in_win_i,
   output logic qual_o
);
   localparam logic [SERR_W-1:0] SAT  = {SERR_W{1'b1}};
   localparam logic [SERR_W-1:0] NEED = SERR_W'(SERR_NEED);

   logic [SERR_W-1:0] cnt_q;
   logic              cs_q;
   logic              edge_w;

   assign edge_w = cs_i & ~cs_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         cs_q  <= 1'b0;
      end else begin
         cs_q <= cs_i;
         if (clr_i)
            cnt_q <= '0;
         else if (edge_w && in_win_i && cnt_q != SAT)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign qual_o = (cnt_q >= NEED);

   a_r10_window_only: assert property (@(posedge clk_i) disable iff (rst_i)
      (!in_win_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/vfs_noise_det.sv
module vfs_noise_det #(
   parameter int unsigned CNT_W  = 14,
   parameter int unsigned WIN_LO = 4000,
   parameter int unsigned WIN_HI = 6000,
   parameter int unsigned W_MIN  = 5,
   parameter int unsigned W_MAX  = 50
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic             vs_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             arm_o
);
   localparam int unsigned   WID_W = vfs_pkg::bits_for(W_MAX + 1);
   localparam logic [WID_W-1:0] WID_SAT = WID_W'(W_MAX + 1);
   localparam logic [WID_W-1:0] WID_MIN = WID_W'(W_MIN);
   localparam logic [WID_W-1:0] WID_MAX = WID_W'(W_MAX);

   logic             vs_q;
   logic [WID_W-1:0] wid_q;
   logic             start_ok_q;
   logic             arm_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         vs_q       <= 1'b0;
         wid_q      <= '0;
         start_ok_q <= 1'b0;
         arm_q      <= 1'b0;
      end else begin
         vs_q <= vs_i;
         if (!en_i || clr_i) begin
            wid_q      <= '0;
            start_ok_q <= 1'b0;
            arm_q      <= 1'b0;
         end else begin
            if (vs_i && wid_q != WID_SAT)
               wid_q <= wid_q + 1'b1;
            if (vs_i && !vs_q) begin
               start_ok_q <= (cnt_i >= CNT_W'(WIN_LO)) && (cnt_i <= CNT_W'(WIN_HI));
               wid_q      <= WID_W'(1);
            end
            if (!vs_i && vs_q) begin
               if (start_ok_q && wid_q >= WID_MIN && wid_q <= WID_MAX)
                  arm_q <= 1'b1;
               wid_q      <= '0;
               start_ok_q <= 1'b0;
            end
         end
      end
   end

   assign arm_o = arm_q;

   a_r7_arm_on_trailing_edge: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(arm_o) |-> $fell(vs_q));
endmodule

// File: rtl/vfield_sync.sv
module vfield_sync #(
   parameter int unsigned SYNC_LEN     = 8400,
   parameter int unsigned FREE_LEN     = 10944,
   parameter int unsigned HOLDOFF      = 7872,
   parameter int unsigned BLANK_LEN    = 672,
   parameter int unsigned SERR_NEED    = 9,
   parameter int unsigned SERR_W       = 4,
   parameter int unsigned CONF_FIELDS  = 7,
   parameter int unsigned PHASE_FIELDS = 8,
   parameter bit          FAST_RESYNC  = 1'b1,
   parameter int unsigned NOISE_LO     = 4000,
   parameter int unsigned NOISE_HI     = 6000,
   parameter int unsigned NOISE_WMIN   = 5,
   parameter int unsigned NOISE_WMAX   = 50
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic csync_i,
   input  logic vsync_i,
   input  logic auto_i,
   output logic ramp_o,
   output logic blank_o,
   output logic locked_o
);
   import vfs_pkg::*;

   localparam int unsigned CNT_W  = bits_for(FREE_LEN);
   localparam int unsigned MISS_W = bits_for(CONF_FIELDS);
   localparam int unsigned PHS_W  = bits_for(PHASE_FIELDS);
   localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(CONF_FIELDS - 1);
   localparam logic [PHS_W-1:0]  PHS_LAST  = PHS_W'(PHASE_FIELDS - 1);

   if (SYNC_LEN >= FREE_LEN || HOLDOFF >= SYNC_LEN || BLANK_LEN >= HOLDOFF) begin : g_bad_lengths
      $error("vfield_sync: field lengths must satisfy BLANK_LEN < HOLDOFF < SYNC_LEN < FREE_LEN");
   end
   if (SERR_NEED == 0 || SERR_NEED >= (1 << SERR_W)) begin : g_bad_serr
      $error("vfield_sync: SERR_NEED must be nonzero and fit SERR_W bits");
   end
   if (CONF_FIELDS == 0 || PHASE_FIELDS == 0) begin : g_bad_fields
      $error("vfield_sync: field tallies must be nonzero");
   end
   if (NOISE_LO > NOISE_HI || NOISE_HI >= HOLDOFF || NOISE_WMIN > NOISE_WMAX) begin : g_bad_noise
      $error("vfield_sync: noise window must lie before the hold-off point");
   end

   lock_e            lock_q;
   logic [MISS_W-1:0] miss_q;
   logic [PHS_W-1:0]  phs_q;
   logic              vs_q;
   logic              locked;
   logic              vs_rise, in_ph, out_ph, rephase, cut;
   logic              wrap, in_win, restart, qual, arm;
   logic [CNT_W-1:0]  cnt;

   assign locked  = (lock_q == LOCK_SYNC);
   assign vs_rise = vsync_i & ~vs_q;
   assign in_ph   = locked & vs_rise & wrap;
   assign out_ph  = locked & vs_rise & in_win & ~wrap;
   assign rephase = out_ph & (phs_q == PHS_LAST);
   assign cut     = auto_i & (locked ? rephase : (vs_rise & in_win));

   vfs_field_ctr #(
      .SYNC_LEN(SYNC_LEN), .FREE_LEN(FREE_LEN), .HOLDOFF(HOLDOFF),
      .BLANK_LEN(BLANK_LEN), .CNT_W(CNT_W)
   ) u_field (
      .clk_i(clk_i), .rst_i(rst_i), .locked_i(locked), .cut_i(cut),
      .cnt_o(cnt), .wrap_o(wrap), .in_win_o(in_win), .restart_o(restart),
      .ramp_o(ramp_o), .blank_o(blank_o)
   );

   vfs_serr_ctr #(.SERR_NEED(SERR_NEED), .SERR_W(SERR_W)) u_serr (
      .clk_i(clk_i), .rst_i(rst_i), .clr_i(restart | ~auto_i),
      .cs_i(csync_i), .in_win_i(in_win), .qual_o(qual)
   );

   if (FAST_RESYNC) begin : g_fast
      vfs_noise_det #(
         .CNT_W(CNT_W), .WIN_LO(NOISE_LO), .WIN_HI(NOISE_HI),
         .W_MIN(NOISE_WMIN), .W_MAX(NOISE_WMAX)
      ) u_noise (
         .clk_i(clk_i), .rst_i(rst_i), .en_i(auto_i & ~locked), .clr_i(restart),
         .vs_i(vsync_i), .cnt_i(cnt), .arm_o(arm)
      );
   end else begin : g_slow
      assign arm = 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lock_q <= LOCK_FREE;
         miss_q <= '0;
         phs_q  <= '0;
         vs_q   <= 1'b0;
      end else begin
         vs_q <= vsync_i;
         if (!auto_i) begin
            lock_q <= LOCK_FREE;
            miss_q <= '0;
            phs_q  <= '0;
         end else begin
            if (!locked || in_ph)
               phs_q <= '0;
            else if (out_ph)
               phs_q <= rephase ? '0 : phs_q + 1'b1;
            if (restart) begin
               if (qual || arm) begin
                  lock_q <= LOCK_SYNC;
                  miss_q <= '0;
               end else if (locked) begin
                  if (miss_q == MISS_LAST) begin
                     lock_q <= LOCK_FREE;
                     miss_q <= '0;
                     phs_q  <= '0;
                  end else begin
                     miss_q <= miss_q + 1'b1;
                  end
               end
            end
         end
      end
   end

   assign locked_o = locked;

   a_r5_lock_drops_at_restart: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(locked_o) |-> $past(restart || !auto_i));
   a_r4_lock_rises_at_restart: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(locked_o) |-> $past(restart));
   a_r9_forced_free: assert property (@(posedge clk_i) disable iff (rst_i)
      !auto_i |=> !locked_o);
   a_r6_tally_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
      phs_q <= PHS_LAST);
endmodule

// File: tb/vfield_sync_bench.sv
`timescale 1ns/1ps
module vfield_sync_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs = 1'b0, vs = 1'b0, mode = 1'b0;
   logic ramp, blank, lk;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   int t_ramp = 0;
   int iv;

   // behavioural reference state
   int m_cnt = 0, m_serr = 0, m_miss = 0, m_phs = 0, m_wid = 0;
   bit m_lock = 0, m_ramp = 0, m_arm = 0, m_ok = 0, m_pvs = 0, m_pcs = 0;

   always #2.5 clk = ~clk;

   vfield_sync u_vfield_sync (
      .clk_i(clk), .rst_i(rst), .csync_i(cs), .vsync_i(vs), .auto_i(mode),
      .ramp_o(ramp), .blank_o(blank), .locked_o(lk)
   );

   always @(posedge clk) begin
      int lim;
      bit vr, cr, fl, wrap, win, rest, en;
      cyc++;
      if (rst) begin
         m_cnt = 0; m_serr = 0; m_miss = 0; m_phs = 0; m_wid = 0;
         m_lock = 0; m_ramp = 0; m_arm = 0; m_ok = 0; m_pvs = 0; m_pcs = 0;
      end else begin
         int n_serr, n_miss, n_phs, n_wid;
         bit n_lock, n_arm, n_ok;
         vr = vs && !m_pvs; cr = cs && !m_pcs; fl = !vs && m_pvs;
         lim = m_lock ? 8399 : 10943;
         wrap = (m_cnt == lim);
         win = (m_cnt >= 7872);
         n_phs = m_phs;
         rest = 0;
         if (!mode) rest = wrap;
         else if (m_lock) begin
            if (vr && win) begin
               if (wrap) n_phs = 0;
               else if (m_phs == 7) begin rest = 1; n_phs = 0; end
               else n_phs = m_phs + 1;
            end
            if (wrap) rest = 1;
         end else rest = wrap || (vr && win);
         en = mode && !m_lock;
         n_arm = m_arm; n_wid = m_wid; n_ok = m_ok;
         if (!en || rest) begin n_wid = 0; n_ok = 0; n_arm = 0; end
         else begin
            if (vs) n_wid = (m_wid < 51) ? m_wid + 1 : 51;
            if (vr) begin n_ok = (m_cnt >= 4000 && m_cnt <= 6000); n_wid = 1; end
            if (fl) begin
               if (m_ok && m_wid >= 5 && m_wid <= 50) n_arm = 1;
               n_wid = 0; n_ok = 0;
            end
         end
         n_lock = m_lock; n_miss = m_miss;
         if (!mode) begin n_lock = 0; n_miss = 0; n_phs = 0; end
         else begin
            if (!m_lock) n_phs = 0;
            if (rest) begin
               if (m_serr >= 9 || m_arm) begin n_lock = 1; n_miss = 0; end
               else if (m_lock) begin
                  if (m_miss == 6) begin n_lock = 0; n_miss = 0; n_phs = 0; end
                  else n_miss = m_miss + 1;
               end
            end
         end
         if (!mode || rest) n_serr = 0;
         else if (cr && win && m_serr < 15) n_serr = m_serr + 1;
         else n_serr = m_serr;
         m_ramp = rest;
         m_cnt = rest ? 0 : m_cnt + 1;
         m_serr = n_serr; m_miss = n_miss; m_phs = n_phs; m_wid = n_wid;
         m_lock = n_lock; m_arm = n_arm; m_ok = n_ok;
         m_pvs = vs; m_pcs = cs;
      end
   end

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (cyc > 0) begin
         vectors++;
         if (ramp !== m_ramp || blank !== (m_cnt < 672) || lk !== m_lock) begin
            miscompares++;
            $display("FAIL R2/R8/R4 cycle %0d: ramp=%b blank=%b locked=%b expected %b %b %b",
                     cyc, ramp, blank, lk, m_ramp, (m_cnt < 672), m_lock);
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cnt(input int k);
      while (m_cnt != k) @(negedge clk);
   endtask

   task automatic wait_ramp();
      do @(negedge clk); while (!ramp);
      iv = cyc - t_ramp;
      t_ramp = cyc;
   endtask

   task automatic serrate(input int n);
      for (int i = 0; i < n; i++) begin
         cs = 1'b1; @(negedge clk);
         cs = 1'b0; repeat (19) @(negedge clk);
      end
   endtask

   task automatic hold_vs(input int n);
      repeat (n) @(negedge clk);
      vs = 1'b0;
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(ramp == 0 && blank == 1 && lk == 0, "R1", {ramp, blank, lk}, 3'b010);
      rst = 1'b0;
      @(negedge clk);
      check(ramp == 0 && blank == 1 && lk == 0, "R1", {ramp, blank, lk}, 3'b010);

      // forced free-run: sync and serrations have no effect
      wait_cnt(7900); serrate(9);
      wait_cnt(8200); vs = 1'b1; @(negedge clk);
      check(ramp == 0, "R9", ramp, 0);
      hold_vs(63);
      wait_cnt(8500); mode = 1'b1;
      wait_ramp();
      check(lk == 0, "R9", lk, 0);
      @(negedge clk);
      check(ramp == 0, "R8", ramp, 1'b0);

      // early sync ignored, out-of-window and 8 serrations do not qualify
      wait_cnt(671);
      check(blank == 1, "R8", blank, 1);
      @(negedge clk);
      check(blank == 0, "R8", blank, 0);
      wait_cnt(3000); vs = 1'b1; @(negedge clk);
      check(ramp == 0, "R3", ramp, 0);
      hold_vs(63);
      wait_cnt(7000); serrate(3);
      wait_cnt(7900); serrate(8);
      wait_ramp();
      check(iv == 10944, "R2", iv, 10944);
      check(lk == 0, "R10", lk, 0);
      check(lk == 0, "R4", lk, 0);

      // 9 serrations and an in-window sync lock the block
      wait_cnt(7900); serrate(9);
      wait_cnt(8200); vs = 1'b1; @(negedge clk);
      check(ramp == 1, "R3", ramp, 1);
      check(lk == 1, "R4", lk, 1);
      t_ramp = cyc;
      hold_vs(63);

      // eight out-of-phase sync pulses, re-phase on the eighth
      for (int f = 0; f < 8; f++) begin
         wait_cnt(7900); serrate(9);
         wait_cnt(8100); vs = 1'b1; @(negedge clk);
         check(ramp == (f == 7), "R6", ramp, (f == 7));
         if (f < 7) begin
            hold_vs(63);
            wait_ramp();
            if (f == 0) check(iv == 8400, "R4", iv, 8400);
         end else begin
            check(lk == 1, "R6", lk, 1);
            hold_vs(63);
         end
      end

      // seven unqualified fields: the seventh drops lock
      for (int f = 0; f < 7; f++) begin
         if (f == 0) begin wait_cnt(7900); serrate(8); end
         wait_ramp();
         check(lk == (f < 6), "R5", lk, (f < 6));
      end

      // noise pulse in mid-field triggers fast resync
      wait_cnt(5000); vs = 1'b1; hold_vs(20);
      @(negedge clk);
      check(lk == 0, "R7", lk, 0);
      wait_ramp();
      check(iv == 10944, "R2", iv, 10944);
      check(lk == 1, "R7", lk, 1);
      repeat (5) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule